// File: doc/BRIEF.md
# Two-Channel Timer Capture/Compare Unit

This block is a pair of timer channels that share one free-running up-counter with a programmable modulo. Each channel holds a 4-bit control code and a value register. Depending on the code, a channel does one of four things:

- leaves its pin with general-purpose I/O and holds a preset output level;
- latches the counter when a selected edge arrives on its capture input;
- sets its flag on a counter match without touching the pin;
- drives its pin on a match by toggling, clearing or setting it.

Channel 0 can also take over channel 1 to form one buffered compare/PWM channel. In that case the two value registers act as a double buffer, and the active one changes only when the counter wraps.

Software writes the modulo, the control codes, the values and the flag-clear mask through a simple write port. Writes take effect at the next clock edge. The counter is controlled by a run input and a hold input; hold forces the counter to zero. A pad mux per channel passes the general-purpose output and enable through unless the timer owns the pin.

Top module: `timer_ccp_pair`

Write addresses:

| Address | Register |
|---|---|
| 0 | modulo |
| 1 | control, channel 0 |
| 2 | value, channel 0 |
| 3 | control, channel 1 |
| 4 | value, channel 1 |
| 5 | flag clear, bit i clears channel i |

Control code bits, from data bit 3 down to bit 0: mode B, mode A, select bit 1, select bit 0.

## Requirements
- R1: While run=1 and hold=0, the count advances by one per clock and wraps from the modulo value to 0. With run=0 the count holds. hold=1 forces the count to 0.
- R2: With select bits 00, pad_out and pad_oe follow gpio_out and gpio_oe. The channel level is preset to 1 when mode A=0 and to 0 when mode A=1.
- R3: With modes B:A=00, select code 01 captures on rising edges only, 10 on falling edges only, and 11 on both edges.
- R4: The capture input passes through two flip-flops. The value register latches the count of the cycle in which the synchronized edge is seen, and the flag is set at the same time.
- R5: With code 0100 (modes 01, select 00), a match sets the flag while the pad still follows gpio.
- R6: With modes B:A=01 and select codes 01, 10 and 11, a match toggles, clears or sets the channel level, which then drives pad_out with pad_oe=1.
- R7: A write of 1 to bit i at address 5 clears flag i. An event in the same cycle wins over the clear.
- R8: When mode B of channel 0 is 1, channel 1's control code has no effect. Channel 1's pad follows gpio and flag 1 is never set.
- R9: In buffered mode, the compare source is chosen by the last value register written (channel 0 or channel 1). The source changes only at a counter wrap.
- R10: No compare match is detected while the counter is not advancing, even if the count equals the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counter advance enable |
| hold | input | 1 | Forces counter to zero |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CW | Write data |
| cap_in | input | 2 | Capture inputs, one per channel |
| gpio_out | input | 2 | General-purpose output values |
| gpio_oe | input | 2 | General-purpose output enables |
| pad_out | output | 2 | Pad output value |
| pad_oe | output | 2 | Pad output enable |
| count | output | CW | Counter value |
| flags | output | 2 | Channel flags |
| ch_level | output | 2 | Timer-side channel output levels |
| ch0_value | output | CW | Channel 0 value register |
| ch1_value | output | CW | Channel 1 value register |

## Verification
The bench builds the block with an 8-bit counter (CW=8) and two synchronizer stages. The 8-bit counter keeps modulo periods of 6 to 41 counts cheap to cover. Wraps, matches and the buffered source switch at a wrap therefore happen many times within a short run. Using two synchronizer stages makes the capture latency a fixed three cycles, so the bench can predict the latched count exactly from the count it observes.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef struct packed {
    logic       mode_b;
    logic       mode_a;
    logic [1:0] sel;
  } chan_ctrl_t;

  localparam logic [1:0] SEL_RELEASE = 2'b00;
  localparam logic [1:0] SEL_TOGGLE  = 2'b01;
  localparam logic [1:0] SEL_CLEAR   = 2'b10;
  localparam logic [1:0] SEL_SET     = 2'b11;

endpackage

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          hold,
  input  logic [CW-1:0] modulo,
  output logic [CW-1:0] count,
  output logic          adv,
  output logic          ovf
);

  logic [CW-1:0] count_d;

  assign adv = run & ~hold;
  assign ovf = adv & (count == modulo);

  always_comb begin
    count_d = count;
    if (hold)     count_d = '0;
    else if (ovf) count_d = '0;
    else if (adv) count_d = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> count == '0);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !hold) |=> $stable(count));

endmodule

// File: rtl/timer_sync.sv
module timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  chan_ctrl_t    ctrl,
  input  logic          val_we,
  input  logic [CW-1:0] val_wdata,
  input  logic          cap_sync,
  input  logic [CW-1:0] count,
  input  logic          adv,
  input  logic [CW-1:0] cmp_val,
  input  logic          flag_clr,
  output logic [CW-1:0] val_q,
  output logic          flag,
  output logic          level,
  output logic          drive,
  output logic          own,
  output logic          evt
);

  logic          prev_q;
  logic          rise, fall, cap_mode, cmp_en, cap_hit, cmp_hit;
  logic [CW-1:0] val_d;
  logic          flag_d, level_d, act_level;

  assign own      = (ctrl.sel != SEL_RELEASE);
  assign cap_mode = own & ~ctrl.mode_b & ~ctrl.mode_a;
  assign cmp_en   = ctrl.mode_b | ctrl.mode_a;
  assign drive    = own & cmp_en;
  assign rise     = cap_sync & ~prev_q;
  assign fall     = ~cap_sync & prev_q;
  assign cap_hit  = cap_mode & ((ctrl.sel[0] & rise) | (ctrl.sel[1] & fall));
  assign cmp_hit  = cmp_en & adv & (count == cmp_val);
  assign evt      = cap_hit | cmp_hit;

  always_comb begin
    unique case (ctrl.sel)
      SEL_TOGGLE: act_level = ~level;
      SEL_CLEAR:  act_level = 1'b0;
      SEL_SET:    act_level = 1'b1;
      default:    act_level = level;
    endcase
  end

  always_comb begin
    val_d = val_q;
    if (cap_hit)     val_d = count;
    else if (val_we) val_d = val_wdata;

    flag_d = flag;
    if (evt)           flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;

    level_d = level;
    if (!own)                 level_d = ~ctrl.mode_a;
    else if (drive & cmp_hit) level_d = act_level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      val_q  <= '0;
      flag   <= 1'b0;
      level  <= 1'b1;
    end else begin
      prev_q <= cap_sync;
      val_q  <= val_d;
      flag   <= flag_d;
      level  <= level_d;
    end
  end

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> (val_q == $past(count)) && flag);
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);
  p_flag_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !evt) |=> !flag);
  p_no_match_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !cap_mode && !flag_clr) |=> $stable(flag));

endmodule

// File: rtl/timer_ccp_pair.sv
module timer_ccp_pair
  import timer_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          hold,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    cap_in,
  input  logic [1:0]    gpio_out,
  input  logic [1:0]    gpio_oe,
  output logic [1:0]    pad_out,
  output logic [1:0]    pad_oe,
  output logic [CW-1:0] count,
  output logic [1:0]    flags,
  output logic [1:0]    ch_level,
  output logic [CW-1:0] ch0_value,
  output logic [CW-1:0] ch1_value
);

  localparam int NCH = 2;
  localparam logic [2:0] A_MOD  = 3'd0;
  localparam logic [2:0] A_FCLR = 3'd5;

  logic [CW-1:0]          mod_q, mod_d;
  chan_ctrl_t [NCH-1:0]   ctrl_q, ctrl_d, ctrl_eff;
  logic [NCH-1:0][CW-1:0] val_q, cmp_val;
  logic [NCH-1:0]         val_we, cap_s, flg, lvl, drv, own, evt, fclr;
  logic                   adv, ovf, buf_mode;
  logic                   pend_q, pend_d, act_q, act_d;

  assign buf_mode = ctrl_q[0].mode_b;

  always_comb begin
    mod_d = mod_q;
    if (wr_en && wr_addr == A_MOD) mod_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mod_q <= '0;
    else        mod_q <= mod_d;
  end

  timer_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .hold(hold), .modulo(mod_q),
    .count(count), .adv(adv), .ovf(ovf)
  );

  assign fclr = (wr_en && wr_addr == A_FCLR) ? wr_data[NCH-1:0] : '0;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [2:0] A_CTRL = 3'(1 + 2*i);
    localparam logic [2:0] A_VAL  = 3'(2 + 2*i);

    assign val_we[i] = wr_en && (wr_addr == A_VAL);

    always_comb begin
      ctrl_d[i] = ctrl_q[i];
      if (wr_en && wr_addr == A_CTRL) ctrl_d[i] = chan_ctrl_t'(wr_data[3:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q[i] <= '0;
      else        ctrl_q[i] <= ctrl_d[i];
    end

    if (i == 0) begin : g_lead
      assign ctrl_eff[i] = ctrl_q[i];
      assign cmp_val[i]  = (buf_mode && act_q) ? val_q[1] : val_q[0];
    end else begin : g_follow
      assign ctrl_eff[i] = buf_mode ? chan_ctrl_t'('0) : ctrl_q[i];
      assign cmp_val[i]  = val_q[i];
    end

    timer_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(cap_in[i]), .q(cap_s[i])
    );

    timer_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl_eff[i]), .val_we(val_we[i]),
      .val_wdata(wr_data), .cap_sync(cap_s[i]), .count(count), .adv(adv),
      .cmp_val(cmp_val[i]), .flag_clr(fclr[i]), .val_q(val_q[i]),
      .flag(flg[i]), .level(lvl[i]), .drive(drv[i]), .own(own[i]),
      .evt(evt[i])
    );

    assign pad_out[i] = own[i] ? lvl[i] : gpio_out[i];
    assign pad_oe[i]  = own[i] ? drv[i] : gpio_oe[i];
  end

  always_comb begin
    pend_d = pend_q;
    act_d  = act_q;
    if (!buf_mode) begin
      pend_d = 1'b0;
      act_d  = 1'b0;
    end else begin
      if (val_we[1])      pend_d = 1'b1;
      else if (val_we[0]) pend_d = 1'b0;
      if (ovf)            act_d  = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign flags     = flg;
  assign ch_level  = lvl;
  assign ch0_value = val_q[0];
  assign ch1_value = val_q[1];

  p_buf_ch1_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_mode |-> !evt[1]);
  p_buf_sel_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_mode && !ovf) |=> $stable(act_q));

endmodule

// File: tb/tb_timer_ccp_pair.sv
module tb_timer_ccp_pair;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n, run, hold, wr_en;
  logic [2:0]    wr_addr;
  logic [CW-1:0] wr_data;
  logic [1:0]    cap_in, gpio_out, gpio_oe, pad_out, pad_oe, flags, ch_level;
  logic [CW-1:0] count, ch0_value, ch1_value;

  int n_chk = 0;
  int n_fail = 0;

  timer_ccp_pair #(.CW(CW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .hold(hold), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .cap_in(cap_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .pad_out(pad_out),
    .pad_oe(pad_oe), .count(count), .flags(flags), .ch_level(ch_level),
    .ch0_value(ch0_value), .ch1_value(ch1_value)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_count(input int v);
    for (int k = 0; k < 600 && count != CW'(v); k++) @(negedge clk);
  endtask

  task automatic setup(input int ch, input int code, input int val, input int md);
    hold = 1'b1; run = 1'b0;
    @(negedge clk);
    wr(3'd0, md);
    wr(3'(1 + 2*ch), code);
    wr(3'(2 + 2*ch), val);
    wr(3'd5, 3);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(count == 0, "R1 reset count", count, 0);
    chk(flags == 0, "R7 reset flags", flags, 0);
    chk(ch_level == 2'b11, "R2 reset preset high", ch_level, 3);
    chk(pad_oe == gpio_oe && pad_out == gpio_out, "R2 reset pads follow gpio", pad_oe, gpio_oe);
  endtask

  task automatic t_counter;
    int exp;
    hold = 1'b1; run = 1'b0; @(negedge clk);
    wr(3'd0, 5);
    chk(count == 0, "R1 hold clears", count, 0);
    hold = 1'b0; run = 1'b1;
    exp = 0;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      exp = (exp == 5) ? 0 : exp + 1;
      chk(count == CW'(exp), "R1 count sequence", count, exp);
    end
    run = 1'b0;
    exp = count;
    repeat (3) @(negedge clk);
    chk(count == CW'(exp), "R1 stop holds", count, exp);
  endtask

  task automatic t_release;
    gpio_out = 2'b10; gpio_oe = 2'b01;
    setup(0, 4'b0100, 3, 9);
    chk(ch_level[0] == 1'b0, "R2 preset low", ch_level[0], 0);
    chk(pad_out[0] == gpio_out[0] && pad_oe[0] == gpio_oe[0], "R2 pad follows gpio", pad_oe[0], gpio_oe[0]);
    hold = 1'b0; run = 1'b1;
    wait_count(3);
    @(negedge clk);
    chk(flags[0] == 1'b1, "R5 software compare flag", flags[0], 1);
    chk(pad_oe[0] == gpio_oe[0] && pad_out[0] == gpio_out[0], "R5 pad not driven", pad_oe[0], gpio_oe[0]);
    run = 1'b0;
    wr(3'd1, 4'b0000);
    @(negedge clk);
    chk(ch_level[0] == 1'b1, "R2 preset high", ch_level[0], 1);
  endtask

  task automatic t_compare(input int code, input logic exp_lvl, input string tag);
    setup(0, code, 4, 9);
    hold = 1'b0; run = 1'b1;
    wait_count(4);
    @(negedge clk);
    chk(ch_level[0] == exp_lvl && pad_out[0] == exp_lvl, tag, ch_level[0], exp_lvl);
    chk(pad_oe[0] == 1'b1, "R6 pad driven", pad_oe[0], 1);
    chk(flags[0] == 1'b1, "R6 flag on match", flags[0], 1);
  endtask

  task automatic t_flags;
    setup(0, 4'b0101, 6, 9);
    hold = 1'b0; run = 1'b1;
    wait_count(6);
    wr(3'd5, 1);
    chk(flags[0] == 1'b1, "R7 set wins over clear", flags[0], 1);
    wr(3'd5, 1);
    chk(flags[0] == 1'b0, "R7 write-one clears", flags[0], 0);
    run = 1'b0;
  endtask

  task automatic t_idle_no_match;
    int c;
    setup(0, 4'b0100, 0, 9);
    hold = 1'b0; run = 1'b1;
    repeat (3) @(negedge clk);
    run = 1'b0;
    c = count;
    wr(3'd2, c);
    wr(3'd5, 1);
    repeat (4) @(negedge clk);
    chk(flags[0] == 1'b0, "R10 no match while stopped", flags[0], 0);
  endtask

  task automatic t_capture(input int code, input logic first_rise, input logic expect_first, input string tag);
    int c;
    cap_in[0] = ~first_rise;
    setup(0, code, 0, 200);
    hold = 1'b0; run = 1'b1;
    repeat (5) @(negedge clk);
    wr(3'd5, 1);
    cap_in[0] = first_rise;
    @(negedge clk);
    @(negedge clk);
    c = count;
    @(negedge clk);
    if (expect_first) begin
      chk(flags[0] == 1'b1, tag, flags[0], 1);
      chk(ch0_value == CW'(c), "R4 latched count", ch0_value, c);
    end else begin
      repeat (3) @(negedge clk);
      chk(flags[0] == 1'b0, tag, flags[0], 0);
    end
    run = 1'b0;
  endtask

  task automatic t_buffered;
    gpio_oe = 2'b00; gpio_out = 2'b00;
    hold = 1'b1; run = 1'b0; @(negedge clk);
    wr(3'd3, 4'b0101);
    wr(3'd1, 4'b1001);
    wr(3'd0, 40);
    wr(3'd2, 10);
    wr(3'd4, 20);
    wr(3'd5, 3);
    @(negedge clk);
    chk(pad_oe[1] == 1'b0 && pad_out[1] == 1'b0, "R8 ch1 pad released", pad_oe[1], 0);
    cap_in[1] = 1'b1;
    hold = 1'b0; run = 1'b1;
    wait_count(10);
    @(negedge clk);
    chk(flags[0] == 1'b1, "R9 old source before wrap", flags[0], 1);
    wr(3'd5, 1);
    cap_in[1] = 1'b0;
    wait_count(20);
    @(negedge clk);
    chk(flags[0] == 1'b0, "R9 no switch before wrap", flags[0], 0);
    wait_count(0);
    wait_count(10);
    @(negedge clk);
    chk(flags[0] == 1'b0, "R9 old value unused after wrap", flags[0], 0);
    wait_count(20);
    @(negedge clk);
    chk(flags[0] == 1'b1, "R9 new source after wrap", flags[0], 1);
    chk(flags[1] == 1'b0, "R8 ch1 flag never set", flags[1], 0);
    run = 1'b0;
  endtask

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; hold = 1'b0; wr_en = 1'b0; wr_addr = '0;
    wr_data = '0; cap_in = '0; gpio_out = 2'b01; gpio_oe = 2'b10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_counter;
    t_release;
    t_compare(4'b0101, 1'b0, "R6 toggle");
    t_compare(4'b0110, 1'b0, "R6 clear");
    t_compare(4'b0111, 1'b1, "R6 set");
    t_compare(4'b0110, 1'b0, "R6 clear after set");
    t_flags;
    t_idle_no_match;
    t_capture(4'b0001, 1'b1, 1'b1, "R3 rising capture");
    t_capture(4'b0001, 1'b0, 1'b0, "R3 rising ignores fall");
    t_capture(4'b0010, 1'b1, 1'b0, "R3 falling ignores rise");
    t_capture(4'b0010, 1'b0, 1'b1, "R3 falling capture");
    t_capture(4'b0011, 1'b1, 1'b1, "R3 both edges rise");
    t_capture(4'b0011, 1'b0, 1'b1, "R3 both edges fall");
    t_buffered;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule